// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block lets a host move packet data between its own 16-bit data port and the word-wide packet memory. No processor touches that memory for these transfers. The host loads a start address and a byte count through a small byte-wide register file. It then writes a command that selects a read or a write direction and sets the run flag. From then on, every accepted data-port access moves one 16-bit word. Each accepted access steps the memory address by two and takes two from the byte count.

In read direction the block fetches the first word as soon as the command arrives. Later words are fetched ahead, one at a time, so a word is normally waiting when the host reads. In write direction the host word sits in a holding register until the memory accepts it. The receive path shares the memory and always wins a conflict. The block waits while the receive path holds the memory.

When the count runs out, a completion status bit rises, and the host clears it by writing 1 to it. An abort command ends a transfer at once. A halt combined with an abort marks the port as stopped, and it stays stopped until a new run command arrives.

Top module: `rdma_host_port`

## Requirements
- R1: The register select codes are as follows. 0 loads the low byte of the address, 1 loads its high byte, 2 loads the low byte of the count and 3 loads its high byte. The loaded address is visible on `mem_addr` while no transfer runs.
- R2: Select 4 is the command. Bits [1:0] are the operation: 1 is read, 2 is write and 3 is abort. Bit 2 is run and bit 3 is halt. A transfer begins only when run=1, halt=0 and the operation is read or write.
- R3: In read direction, the word at the start address is fetched when the command is accepted. Each host read returns the word at the current transfer address, with the lower byte address in the low byte. The block then fetches the next word if bytes remain.
- R4: In write direction, each accepted host word is written to the current transfer address. `dp_ready` stays low until that memory write has taken place.
- R5: Every accepted access takes two from the count, and the count never drops below zero. An odd count therefore ends with one full word access. A run command given with a count of zero completes at once, with no memory access.
- R6: Status bit 0 (done) rises when the count reaches zero. In read direction this happens on the last host read. In write direction it happens on the last memory write. `busy_o` falls in the same cycle.
- R7: Writing select 5 clears status bit 0 where the written bit 0 is 1. Status bit 1 is not affected by this write. A completion in the same cycle wins over the clear.
- R8: An abort command (operation 3), or any command with halt=1, ends a running transfer at once. No further memory access follows, and done is not set.
- R9: After reset, status reads stopped=1 (bit 1) and done=0, and `busy_o` is 0. A command with halt=1 and operation 3 sets bit 1. Bit 1 stays set until a command with run=1 and halt=0.
- R10: Data-port accesses made while `dp_ready` is low change nothing, and `dp_rdata` is zero then.
- R11: While `rx_req` is high, `mem_en` stays low and `rx_gnt` is high. A pending transfer step waits for `rx_req` to fall.
- R12: The transfer address wraps from 0xFFFE to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| status_o | output | 2 | {stopped, done} |
| busy_o | output | 1 | Transfer in progress |
| dp_rd | input | 1 | Host data-port read |
| dp_wr | input | 1 | Host data-port write |
| dp_wdata | input | 16 | Host write word |
| dp_rdata | output | 16 | Host read word |
| dp_ready | output | 1 | Data port can accept an access |
| rx_req | input | 1 | Receive path memory request |
| rx_gnt | output | 1 | Receive path memory grant |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 16 | Memory byte address (word aligned) |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid one cycle after a read |

## Verification
Some properties are checked by assertions on every cycle. At most one read word is fetched or held at any time. A fetch in flight lands in the buffer unless a command cancels it. The count never grows without a register load, and it stays unchanged while the data port is not ready. Completion sets done, a write of 1 to the status clears it, and a halt with abort latches the stopped flag, which holds until a run command. Other behaviour only the bench scenarios can show. These cover the word values returned after prefetch, odd and zero counts, and address wrap. They also cover stalls behind the receive path, abort in the middle of a transfer, and the zero read value after completion.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ABORT = 2'd3
  } rdma_op_e;

  typedef struct packed {
    logic     halt;
    logic     run;
    rdma_op_e op;
  } rdma_cmd_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_CNT_LO  = 3'd2,
    SEL_CNT_HI  = 3'd3,
    SEL_CMD     = 3'd4,
    SEL_STAT    = 3'd5
  } rdma_sel_e;
endpackage

// File: rtl/rdma_cmd_ctrl.sv
module rdma_cmd_ctrl
  import rdma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             xfer_end,
  output logic             ld_addr_lo,
  output logic             ld_addr_hi,
  output logic             ld_cnt_lo,
  output logic             ld_cnt_hi,
  output logic             go_read,
  output logic             go_write,
  output logic             kill,
  output logic             done_o,
  output logic             stopped_o
);
  rdma_cmd_t cmd;
  logic cmd_wr, stat_wr, run_ok;
  logic done_q, done_d, stop_q, stop_d;

  always_comb begin
    cmd        = rdma_cmd_t'(reg_wdata[3:0]);
    cmd_wr     = reg_we && (reg_sel == SEL_CMD);
    stat_wr    = reg_we && (reg_sel == SEL_STAT);
    ld_addr_lo = reg_we && (reg_sel == SEL_ADDR_LO);
    ld_addr_hi = reg_we && (reg_sel == SEL_ADDR_HI);
    ld_cnt_lo  = reg_we && (reg_sel == SEL_CNT_LO);
    ld_cnt_hi  = reg_we && (reg_sel == SEL_CNT_HI);
    run_ok     = cmd.run && !cmd.halt;
    go_read    = cmd_wr && run_ok && (cmd.op == OP_READ);
    go_write   = cmd_wr && run_ok && (cmd.op == OP_WRITE);
    kill       = cmd_wr && ((cmd.op == OP_ABORT) || cmd.halt);
  end

  always_comb begin
    done_d = done_q;
    if (stat_wr && reg_wdata[0]) done_d = 1'b0;
    if (xfer_end)                done_d = 1'b1;
    stop_d = stop_q;
    if (cmd_wr && cmd.halt && (cmd.op == OP_ABORT)) stop_d = 1'b1;
    else if (cmd_wr && run_ok)                      stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  assign done_o    = done_q;
  assign stopped_o = stop_q;

  assert_end_sets_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_q);
  assert_w1c_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[0] && !xfer_end) |=> !done_q);
  assert_halt_abort_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd.halt && (cmd.op == OP_ABORT)) |=> stop_q);
  assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !(cmd_wr && run_ok)) |=> stop_q);
endmodule

// File: rtl/rdma_xfer_engine.sv
module rdma_xfer_engine #(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_addr_lo,
  input  logic               ld_addr_hi,
  input  logic               ld_cnt_lo,
  input  logic               ld_cnt_hi,
  input  logic [REG_W-1:0]   ld_byte,
  input  logic               go_read,
  input  logic               go_write,
  input  logic               kill,
  input  logic               dp_rd,
  input  logic               dp_wr,
  input  logic [2*REG_W-1:0] dp_wdata,
  output logic               dp_ready,
  output logic [2*REG_W-1:0] dp_rdata,
  input  logic               rx_req,
  output logic               mem_en,
  output logic               mem_we,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_wdata,
  input  logic [2*REG_W-1:0] mem_rdata,
  output logic               busy,
  output logic               xfer_end
);
  localparam int WORD_W = 2 * REG_W;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  logic [WORD_W-1:0] addr_q, addr_d, cnt_q, cnt_d, buf_q, buf_d, cnt_dec;
  logic active_q, active_d, rd_q, rd_d, bufv_q, bufv_d;
  logic fpend_q, fpend_d, wpend_q, wpend_d;
  logic fetch_need, wr_need, rd_take, wr_take, go_any;

  always_comb begin
    fetch_need = active_q && rd_q && !bufv_q && !fpend_q && (cnt_q != '0);
    wr_need    = active_q && !rd_q && wpend_q;
    mem_en     = (fetch_need || wr_need) && !rx_req;
    mem_we     = wr_need;
    rd_take    = active_q && rd_q && bufv_q && dp_rd;
    wr_take    = active_q && !rd_q && !wpend_q && dp_wr;
    cnt_dec    = (cnt_q > STEP) ? cnt_q - STEP : '0;
    go_any     = go_read || go_write;
  end

  always_comb begin
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    buf_d    = buf_q;
    active_d = active_q;
    rd_d     = rd_q;
    bufv_d   = bufv_q;
    fpend_d  = fpend_q;
    wpend_d  = wpend_q;
    xfer_end = 1'b0;
    if (ld_addr_lo) addr_d[REG_W-1:0]      = ld_byte;
    if (ld_addr_hi) addr_d[WORD_W-1:REG_W] = ld_byte;
    if (ld_cnt_lo)  cnt_d[REG_W-1:0]       = ld_byte;
    if (ld_cnt_hi)  cnt_d[WORD_W-1:REG_W]  = ld_byte;
    if (mem_en) begin
      addr_d = addr_q + STEP;
      if (!wr_need) fpend_d = 1'b1;
    end
    if (fpend_q) begin
      buf_d   = mem_rdata;
      bufv_d  = 1'b1;
      fpend_d = 1'b0;
    end
    if (rd_take) begin
      bufv_d = 1'b0;
      cnt_d  = cnt_dec;
      if (cnt_dec == '0) begin
        active_d = 1'b0;
        xfer_end = 1'b1;
      end
    end
    if (wr_take) begin
      buf_d   = dp_wdata;
      wpend_d = 1'b1;
      cnt_d   = cnt_dec;
    end
    if (mem_en && wr_need) begin
      wpend_d = 1'b0;
      if (cnt_q == '0) begin
        active_d = 1'b0;
        xfer_end = 1'b1;
      end
    end
    if (go_any) begin
      rd_d     = go_read;
      bufv_d   = 1'b0;
      fpend_d  = 1'b0;
      wpend_d  = 1'b0;
      active_d = (cnt_q != '0);
      if (cnt_q == '0) xfer_end = 1'b1;
    end
    if (kill) begin
      active_d = 1'b0;
      bufv_d   = 1'b0;
      fpend_d  = 1'b0;
      wpend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      buf_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      bufv_q   <= 1'b0;
      fpend_q  <= 1'b0;
      wpend_q  <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      buf_q    <= buf_d;
      active_q <= active_d;
      rd_q     <= rd_d;
      bufv_q   <= bufv_d;
      fpend_q  <= fpend_d;
      wpend_q  <= wpend_d;
    end
  end

  assign dp_ready  = active_q && (rd_q ? bufv_q : !wpend_q);
  assign dp_rdata  = (active_q && rd_q && bufv_q) ? buf_q : '0;
  assign mem_addr  = addr_q;
  assign mem_wdata = buf_q;
  assign busy      = active_q;

  assert_single_word_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bufv_q && fpend_q));
  assert_fetch_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fpend_q && !kill && !go_any) |=> bufv_q);
  assert_count_never_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_cnt_lo || ld_cnt_hi) |=> (cnt_q <= $past(cnt_q)));
  assert_ignored_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_ready && !ld_cnt_lo && !ld_cnt_hi) |=> $stable(cnt_q));
  assert_no_mem_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !mem_en);
endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
  import rdma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [1:0]         status_o,
  output logic               busy_o,
  input  logic               dp_rd,
  input  logic               dp_wr,
  input  logic [2*REG_W-1:0] dp_wdata,
  output logic [2*REG_W-1:0] dp_rdata,
  output logic               dp_ready,
  input  logic               rx_req,
  output logic               rx_gnt,
  output logic               mem_en,
  output logic               mem_we,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_wdata,
  input  logic [2*REG_W-1:0] mem_rdata
);
  logic ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi;
  logic go_read, go_write, kill, xfer_end, done, stopped;

  rdma_cmd_ctrl #(.REG_W(REG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xfer_end(xfer_end),
    .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
    .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
    .go_read(go_read), .go_write(go_write), .kill(kill),
    .done_o(done), .stopped_o(stopped)
  );

  rdma_xfer_engine #(.REG_W(REG_W)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
    .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi), .ld_byte(reg_wdata),
    .go_read(go_read), .go_write(go_write), .kill(kill),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_ready(dp_ready), .dp_rdata(dp_rdata),
    .rx_req(rx_req), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy_o), .xfer_end(xfer_end)
  );

  assign status_o = {stopped, done};
  assign rx_gnt   = rx_req;
endmodule

// File: tb/rdma_host_port_tb.sv
module rdma_host_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, reg_we, dp_rd, dp_wr, rx_req;
  logic [2:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [15:0] dp_wdata, dp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [1:0] status_o;
  logic busy_o, dp_ready, rx_gnt, mem_en, mem_we;

  rdma_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status_o(status_o), .busy_o(busy_o),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .dp_ready(dp_ready), .rx_req(rx_req), .rx_gnt(rx_gnt), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R9";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h5A};
  endfunction

  // memory environment
  logic [15:0] env_mem [int];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) env_mem[int'(mem_addr >> 1)] = mem_wdata;
      else mem_rdata <= env_mem.exists(int'(mem_addr >> 1)) ?
                        env_mem[int'(mem_addr >> 1)] : pat(mem_addr);
    end
  end

  // behavioural reference model
  logic [15:0] ref_mem [int];
  logic m_act, m_rd, m_bv, m_fp, m_wp, m_done, m_stop;
  logic [15:0] m_addr, m_cnt, m_buf, m_fdata;
  wire m_fetch = m_act && m_rd && !m_bv && !m_fp && (m_cnt != 16'd0);
  wire m_wneed = m_act && !m_rd && m_wp;
  wire m_go    = (m_fetch || m_wneed) && !rx_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_bv = 0; m_fp = 0; m_wp = 0; m_done = 0; m_stop = 1;
      m_addr = 0; m_cnt = 0; m_buf = 0; m_fdata = 0;
    end else begin
      automatic logic wneed = m_wneed;
      automatic logic gom = m_go;
      automatic logic fp0 = m_fp;
      automatic logic rtake = m_act && m_rd && m_bv && dp_rd;
      automatic logic wtake = m_act && !m_rd && !m_wp && dp_wr;
      automatic logic [15:0] old_cnt = m_cnt;
      automatic logic [15:0] old_buf = m_buf;
      automatic logic [15:0] dec = (m_cnt > 16'd2) ? m_cnt - 16'd2 : 16'd0;
      automatic logic fin = 1'b0;
      automatic logic cw = reg_we && (reg_sel == 3'd4);
      automatic logic [1:0] op = reg_wdata[1:0];
      automatic logic run = reg_wdata[2];
      automatic logic halt = reg_wdata[3];
      if (reg_we && reg_sel == 3'd0) m_addr[7:0]  = reg_wdata;
      if (reg_we && reg_sel == 3'd1) m_addr[15:8] = reg_wdata;
      if (reg_we && reg_sel == 3'd2) m_cnt[7:0]   = reg_wdata;
      if (reg_we && reg_sel == 3'd3) m_cnt[15:8]  = reg_wdata;
      if (gom) begin
        if (wneed) begin
          ref_mem[int'(m_addr >> 1)] = old_buf;
          m_wp = 0;
          if (old_cnt == 0) begin m_act = 0; fin = 1; end
        end else begin
          m_fdata = ref_mem.exists(int'(m_addr >> 1)) ? ref_mem[int'(m_addr >> 1)] : pat(m_addr);
          m_fp = 1;
        end
        m_addr = m_addr + 16'd2;
      end
      if (fp0) begin m_buf = m_fdata; m_bv = 1; m_fp = 0; end
      if (rtake) begin
        m_bv = 0; m_cnt = dec;
        if (dec == 0) begin m_act = 0; fin = 1; end
      end
      if (wtake) begin m_buf = dp_wdata; m_wp = 1; m_cnt = dec; end
      if (cw && run && !halt && (op == 2'd1 || op == 2'd2)) begin
        m_rd = (op == 2'd1); m_bv = 0; m_fp = 0; m_wp = 0;
        if (old_cnt == 0) fin = 1; else m_act = 1;
      end
      if (cw && (op == 2'd3 || halt)) begin m_act = 0; m_bv = 0; m_fp = 0; m_wp = 0; end
      if (reg_we && reg_sel == 3'd5 && reg_wdata[0]) m_done = 0;
      if (fin) m_done = 1;
      if (cw && halt && op == 2'd3) m_stop = 1;
      else if (cw && run && !halt) m_stop = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "busy", 32'(busy_o), 32'(m_act));
      chk(cur_req, "status", 32'(status_o), 32'({m_stop, m_done}));
      chk(cur_req, "dp_ready", 32'(dp_ready), 32'(m_act && (m_rd ? m_bv : !m_wp)));
      chk(cur_req, "dp_rdata", 32'(dp_rdata), 32'((m_act && m_rd && m_bv) ? m_buf : 16'd0));
      chk(cur_req, "mem_en", 32'(mem_en), 32'(m_go));
      chk(cur_req, "mem_addr", 32'(mem_addr), 32'(m_addr));
      chk("R11", "rx_gnt", 32'(rx_gnt), 32'(rx_req));
      if (m_go) chk(cur_req, "mem_we", 32'(mem_we), 32'(m_wneed));
      if (m_go && m_wneed) chk(cur_req, "mem_wdata", 32'(mem_wdata), 32'(m_buf));
    end
  end

  // stimulus helpers
  task automatic cycle();
    @(negedge clk); #1;
  endtask

  task automatic reg_wr(logic [2:0] sel, logic [7:0] val);
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    cycle();
    reg_we = 0;
  endtask

  task automatic setup(logic [15:0] a, logic [15:0] n);
    reg_wr(3'd0, a[7:0]); reg_wr(3'd1, a[15:8]);
    reg_wr(3'd2, n[7:0]); reg_wr(3'd3, n[15:8]);
  endtask

  task automatic host_rd(output logic [15:0] d);
    while (!dp_ready) cycle();
    d = dp_rdata; dp_rd = 1;
    cycle();
    dp_rd = 0;
  endtask

  task automatic host_wr(logic [15:0] d);
    while (!dp_ready) cycle();
    dp_wdata = d; dp_wr = 1;
    cycle();
    dp_wr = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) cycle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    dp_rd = 0; dp_wr = 0; dp_wdata = 0; rx_req = 0;
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    // R9 reset state
    chk("R9", "reset status", 32'(status_o), 32'h2);
    chk("R9", "reset busy", 32'(busy_o), 32'h0);
    chk("R10", "reset dp_ready", 32'(dp_ready), 32'h0);

    // R1 byte loads
    cur_req = "R1";
    setup(16'h1234, 16'd8);
    chk("R1", "loaded address", 32'(mem_addr), 32'h1234);

    // R3 read of four words, R2 run clears stopped
    cur_req = "R3";
    setup(16'h0100, 16'd8);
    reg_wr(3'd4, 8'h05);
    chk("R2", "stopped cleared by run", 32'(status_o[1]), 32'h0);
    for (int i = 0; i < 4; i++) begin
      host_rd(d);
      chk("R3", "read word", 32'(d), 32'(pat(16'h0100 + 16'(2 * i))));
    end
    chk("R6", "done after reads", 32'(status_o), 32'h1);
    chk("R6", "idle after reads", 32'(busy_o), 32'h0);

    // R10 access after completion ignored
    cur_req = "R10";
    dp_rd = 1; cycle(); dp_rd = 0;
    chk("R10", "rdata after done", 32'(dp_rdata), 32'h0);
    chk("R10", "still idle", 32'(busy_o), 32'h0);

    // R7 write-1-to-clear
    cur_req = "R7";
    reg_wr(3'd5, 8'h01);
    chk("R7", "done cleared", 32'(status_o), 32'h0);

    // R4 write with odd count, R5
    cur_req = "R4";
    setup(16'h0200, 16'd5);
    reg_wr(3'd4, 8'h06);
    host_wr(16'hBEEF); host_wr(16'h1357); host_wr(16'h00A5);
    wait_idle();
    chk("R5", "odd write done", 32'(status_o[0]), 32'h1);
    reg_wr(3'd5, 8'h01);
    setup(16'h0200, 16'd6);
    reg_wr(3'd4, 8'h05);
    host_rd(d); chk("R4", "readback 0", 32'(d), 32'hBEEF);
    host_rd(d); chk("R4", "readback 1", 32'(d), 32'h1357);
    host_rd(d); chk("R4", "readback 2", 32'(d), 32'h00A5);
    reg_wr(3'd5, 8'h01);

    // R11 receive path priority
    cur_req = "R11";
    rx_req = 1;
    setup(16'h0400, 16'd4);
    reg_wr(3'd4, 8'h05);
    for (int i = 0; i < 3; i++) begin
      chk("R11", "stalled mem_en", 32'(mem_en), 32'h0);
      chk("R11", "stalled ready", 32'(dp_ready), 32'h0);
      cycle();
    end
    rx_req = 0;
    host_rd(d); chk("R11", "word after stall", 32'(d), 32'(pat(16'h0400)));
    host_rd(d); chk("R11", "second word", 32'(d), 32'(pat(16'h0402)));
    reg_wr(3'd5, 8'h01);

    // R8 abort mid-transfer
    cur_req = "R8";
    setup(16'h0300, 16'd10);
    reg_wr(3'd4, 8'h05);
    host_rd(d);
    reg_wr(3'd4, 8'h03);
    chk("R8", "busy after abort", 32'(busy_o), 32'h0);
    for (int i = 0; i < 3; i++) begin
      chk("R8", "no mem after abort", 32'(mem_en), 32'h0);
      cycle();
    end
    chk("R8", "done not set", 32'(status_o[0]), 32'h0);

    // R9 halt with abort, R7 w1c leaves stopped
    cur_req = "R9";
    reg_wr(3'd4, 8'h0B);
    chk("R9", "stopped set", 32'(status_o[1]), 32'h1);
    reg_wr(3'd5, 8'hFF);
    chk("R7", "stopped kept by w1c", 32'(status_o[1]), 32'h1);
    // R2 run with halt does not start
    cur_req = "R2";
    setup(16'h0500, 16'd4);
    reg_wr(3'd4, 8'h0D);
    chk("R2", "run+halt no start", 32'(busy_o), 32'h0);
    chk("R9", "still stopped", 32'(status_o[1]), 32'h1);
    reg_wr(3'd4, 8'h04);
    chk("R9", "run clears stopped", 32'(status_o[1]), 32'h0);

    // R5 zero count completes at once
    cur_req = "R5";
    setup(16'h0600, 16'd0);
    reg_wr(3'd4, 8'h05);
    chk("R5", "zero count done", 32'(status_o[0]), 32'h1);
    chk("R5", "zero count idle", 32'(busy_o), 32'h0);
    reg_wr(3'd5, 8'h01);
    // R5 odd read count 3 needs two words
    setup(16'h0700, 16'd3);
    reg_wr(3'd4, 8'h05);
    host_rd(d); chk("R5", "odd read w0", 32'(d), 32'(pat(16'h0700)));
    chk("R5", "busy mid odd", 32'(busy_o), 32'h1);
    host_rd(d); chk("R5", "odd read w1", 32'(d), 32'(pat(16'h0702)));
    chk("R5", "odd read done", 32'(status_o[0]), 32'h1);
    reg_wr(3'd5, 8'h01);

    // R12 address wrap
    cur_req = "R12";
    setup(16'hFFFE, 16'd4);
    reg_wr(3'd4, 8'h05);
    host_rd(d); chk("R12", "word at top", 32'(d), 32'(pat(16'hFFFE)));
    host_rd(d); chk("R12", "word after wrap", 32'(d), 32'(pat(16'h0000)));
    cycle();

    summary();
    $finish;
  end
endmodule